// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block turns a serial bit stream into a keyed carrier suitable for driving an infrared emitter without external logic. It sits in front of the serial transmit pin: with the function disabled the serial transmit line reaches the pin untouched; with it enabled the pin carries a waveform built from two carrier inputs that come from timer PWM channels. The carriers and the serial transmitter are produced elsewhere.

The modulating bit is taken either from the serial transmit line or from a software-held bit, loaded through a one-cycle write strobe. In amplitude keying the pin carries carrier A for a 1 and stays low for a 0; in frequency keying it carries carrier A for a 1 and carrier B for a 0. A polarity control inverts the keyed waveform. The pin is driven from a flop on the system clock, so coincident data and carrier edges cannot produce glitches.

A small state machine names the symbol being sent. Its states are ST_BYPASS (function disabled), ST_MARK (enabled, data bit 1) and ST_SPACE (enabled, data bit 0). The transitions are: any state to ST_BYPASS when the enable input is low; any state to ST_MARK when enabled with the selected data bit high; any state to ST_SPACE when enabled with the selected data bit low. The next state is decoded into the output flop in the same cycle.

Top module: `ir_carrier_mod`

## Requirements
- R1: During and just after reset the output is 1 and the software data bit is 0, so an enabled block with the software bit selected and amplitude keying drives 0 on its first keyed cycle.
- R2: With `mod_en_i` = 0 the output equals `uart_txd_i` one clock later; `pol_inv_i`, `mode_fsk_i`, `data_sel_sw_i` and both carriers have no effect.
- R3: Enabled with the selected data bit 1 and `pol_inv_i` = 0, the output equals `carrier_a_i` one clock later, in both modes.
- R4: Enabled in amplitude keying (`mode_fsk_i` = 0) with the selected data bit 0 and `pol_inv_i` = 0, the output is 0 one clock later, whatever the carriers do.
- R5: Enabled in frequency keying (`mode_fsk_i` = 1) with the selected data bit 0 and `pol_inv_i` = 0, the output equals `carrier_b_i` one clock later.
- R6: Enabled with `pol_inv_i` = 1, the output is the inverse of what R3, R4 or R5 give.
- R7: `data_sel_sw_i` = 0 selects `uart_txd_i` as data; `data_sel_sw_i` = 1 selects the software data bit, and `uart_txd_i` is then ignored.
- R8: A clock edge with `sw_wr_i` = 1 loads `sw_data_i` into the software data bit, whatever data source is selected; it is used from the next cycle and holds until the next write.
- R9: Every input change reaches the output exactly one clock later (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| uart_txd_i | input | 1 | Serial transmit line |
| carrier_a_i | input | 1 | Carrier A from a timer PWM channel |
| carrier_b_i | input | 1 | Carrier B from a timer PWM channel |
| mod_en_i | input | 1 | 1 enables modulation, 0 passes the serial line through |
| pol_inv_i | input | 1 | 1 inverts the keyed output |
| mode_fsk_i | input | 1 | 0 amplitude keying, 1 frequency keying |
| data_sel_sw_i | input | 1 | 0 serial line is data, 1 software bit is data |
| sw_wr_i | input | 1 | Write strobe for the software data bit |
| sw_data_i | input | 1 | Value loaded on a write |
| ir_out_o | output | 1 | Registered pin output |

## Verification
The hardest situation to reach is the software bit being written while the serial line is still the selected source, then used after the source is switched, because the write must be stored but stay invisible until then. The stimulus writes a 1 with the serial source selected and the serial line low, checks that the output remains at the keyed-space level, then selects the software source with the serial line toggling and checks that the carrier appears and the serial line has no effect for several cycles before a write of 0 returns the output to idle. The modulation paths are swept with every carrier and data combination, so a carrier toggling during a space or in bypass is seen to have no effect.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_MARK   = 2'd1,
        ST_SPACE  = 2'd2
    } ir_state_e;

    typedef enum logic {
        KEY_ASK = 1'b0,
        KEY_FSK = 1'b1
    } ir_key_e;

    typedef enum logic {
        SRC_UART = 1'b0,
        SRC_SW   = 1'b1
    } ir_src_e;

endpackage

// File: rtl/ir_swdata_reg.sv
module ir_swdata_reg #(
    parameter logic SW_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    output logic bit_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_o <= SW_RST;
        end else if (wr_i) begin
            bit_o <= wdata_i;
        end
    end

    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (bit_o == $past(wdata_i)));                                   // R8
    AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(bit_o));                                            // R8

endmodule

// File: rtl/ir_ctrl_fsm.sv
module ir_ctrl_fsm
    import ir_mod_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  ir_src_e   src_i,
    input  logic      uart_i,
    input  logic      sw_bit_i,
    output ir_state_e state_d_o,
    output ir_state_e state_q_o
);

    logic data_bit;

    always_comb begin
        data_bit = (src_i == SRC_SW) ? sw_bit_i : uart_i;
    end

    // next-state decode
    always_comb begin
        state_d_o = state_q_o;
        unique case (state_q_o)
            ST_BYPASS, ST_MARK, ST_SPACE: begin
                if (!en_i)         state_d_o = ST_BYPASS;
                else if (data_bit) state_d_o = ST_MARK;
                else               state_d_o = ST_SPACE;
            end
            default:               state_d_o = ST_BYPASS;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q_o <= ST_BYPASS;
        else        state_q_o <= state_d_o;
    end

    AST_FSM_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q_o == ST_BYPASS));                                  // R2
    AST_SRC_SW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && src_i == SRC_SW && sw_bit_i) |=> (state_q_o == ST_MARK));    // R7
    AST_SRC_UART_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && src_i == SRC_UART && !uart_i) |=> (state_q_o == ST_SPACE));  // R7

endmodule

// File: rtl/ir_out_stage.sv
module ir_out_stage
    import ir_mod_pkg::*;
#(
    parameter logic OUT_RST = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  ir_state_e state_d_i,
    input  ir_key_e   key_i,
    input  logic      pol_i,
    input  logic      uart_i,
    input  logic      car_a_i,
    input  logic      car_b_i,
    output logic      out_o
);

    logic out_d;

    // output decode from the next state
    always_comb begin
        out_d = OUT_RST;
        unique case (state_d_i)
            ST_BYPASS: out_d = uart_i;
            ST_MARK:   out_d = car_a_i ^ pol_i;
            ST_SPACE:  out_d = ((key_i == KEY_FSK) ? car_b_i : 1'b0) ^ pol_i;
            default:   out_d = OUT_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_o <= OUT_RST;
        else        out_o <= out_d;
    end

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d_i == ST_BYPASS) |=> (out_o == $past(uart_i)));               // R2
    AST_MARK_CARRIER_A: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d_i == ST_MARK) |=> (out_o == ($past(car_a_i) ^ $past(pol_i)))); // R3
    AST_ASK_SPACE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d_i == ST_SPACE && key_i == KEY_ASK) |=> (out_o == $past(pol_i))); // R4
    AST_FSK_SPACE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d_i == ST_SPACE && key_i == KEY_FSK) |=> (out_o == ($past(car_b_i) ^ $past(pol_i)))); // R5

endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
    import ir_mod_pkg::*;
#(
    parameter logic OUT_RST = 1'b1,
    parameter logic SW_RST  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uart_txd_i,
    input  logic carrier_a_i,
    input  logic carrier_b_i,
    input  logic mod_en_i,
    input  logic pol_inv_i,
    input  logic mode_fsk_i,
    input  logic data_sel_sw_i,
    input  logic sw_wr_i,
    input  logic sw_data_i,
    output logic ir_out_o
);

    logic      sw_bit;
    ir_state_e st_d;
    ir_state_e st_q;
    ir_src_e   src;
    ir_key_e   key;

    assign src = data_sel_sw_i ? SRC_SW : SRC_UART;
    assign key = mode_fsk_i ? KEY_FSK : KEY_ASK;

    ir_swdata_reg #(.SW_RST(SW_RST)) u_swdata (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (sw_wr_i),
        .wdata_i (sw_data_i),
        .bit_o   (sw_bit)
    );

    ir_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (mod_en_i),
        .src_i     (src),
        .uart_i    (uart_txd_i),
        .sw_bit_i  (sw_bit),
        .state_d_o (st_d),
        .state_q_o (st_q)
    );

    ir_out_stage #(.OUT_RST(OUT_RST)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d_i (st_d),
        .key_i     (key),
        .pol_i     (pol_inv_i),
        .uart_i    (uart_txd_i),
        .car_a_i   (carrier_a_i),
        .car_b_i   (carrier_b_i),
        .out_o     (ir_out_o)
    );

    AST_STATE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en_i && !data_sel_sw_i && uart_txd_i) |=> (st_q == ST_MARK));    // R9

endmodule

// File: tb/ir_carrier_mod_tb.sv
module ir_carrier_mod_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uart_txd = 1'b1, car_a = 1'b0, car_b = 1'b0;
    logic mod_en = 1'b0, pol_inv = 1'b0, mode_fsk = 1'b0, sel_sw = 1'b0;
    logic sw_wr = 1'b0, sw_data = 1'b0;
    logic ir_out;

    always #10 clk = ~clk;   // 50 MHz

    ir_carrier_mod u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .uart_txd_i    (uart_txd),
        .carrier_a_i   (car_a),
        .carrier_b_i   (car_b),
        .mod_en_i      (mod_en),
        .pol_inv_i     (pol_inv),
        .mode_fsk_i    (mode_fsk),
        .data_sel_sw_i (sel_sw),
        .sw_wr_i       (sw_wr),
        .sw_data_i     (sw_data),
        .ir_out_o      (ir_out)
    );

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    logic model_sw = 1'b0;
    logic mon_on   = 1'b0;
    logic done     = 1'b0;

    function automatic logic model_out(logic en, logic pol, logic fsk, logic ssw,
                                       logic u, logic swb, logic a, logic b);
        logic d;
        logic raw;
        if (!en) return u;
        d   = ssw ? swb : u;
        raw = d ? a : (fsk ? b : 1'b0);
        return raw ^ pol;
    endfunction

    // driver: applies one cycle of stimulus and pushes the expected output
    task automatic drive(input logic en, input logic pol, input logic fsk, input logic ssw,
                         input logic u, input logic a, input logic b,
                         input logic wr, input logic wd, input string tag);
        sb_item_t it;
        @(negedge clk);
        mod_en = en; pol_inv = pol; mode_fsk = fsk; sel_sw = ssw;
        uart_txd = u; car_a = a; car_b = b; sw_wr = wr; sw_data = wd;
        it.exp = model_out(en, pol, fsk, ssw, u, model_sw, a, b);
        it.tag = tag;
        sb_q.push_back(it);
        if (wr) model_sw = wd;
    endtask

    // monitor: compares away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on && sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (ir_out !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s: ir_out=%b expected=%b at %0t", it.tag, ir_out, it.exp, $time);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset level
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (ir_out !== 1'b1) begin
            n_fails++;
            $display("FAIL R1: ir_out=%b expected=1 during reset", ir_out);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: software bit resets to 0
        drive(1, 0, 0, 1, 1, 1, 1, 0, 0, "R1");

        // R2: bypass ignores polarity, mode, source and carriers
        for (int i = 0; i < 16; i++) begin
            logic [3:0] v;
            v = i[3:0];
            drive(0, v[0], v[1], v[3], v[2] ^ v[3], v[1], v[3], 0, 0, "R2");
        end

        // R3 / R4: amplitude keying from the serial line
        for (int i = 0; i < 16; i++) begin
            logic [3:0] v;
            v = i[3:0];
            drive(1, 0, 0, 0, v[2], v[0], v[1], 0, 0, v[2] ? "R3" : "R4");
        end

        // R3 / R5: frequency keying from the serial line
        for (int i = 0; i < 16; i++) begin
            logic [3:0] v;
            v = i[3:0];
            drive(1, 0, 1, 0, v[2], v[0], v[1], 0, 0, v[2] ? "R3" : "R5");
        end

        // R6: inverted polarity in both modes
        for (int i = 0; i < 16; i++) begin
            logic [3:0] v;
            v = i[3:0];
            drive(1, 1, v[3], 0, v[2], v[0], v[1], 0, 0, "R6");
        end

        // R8: write while the serial line is selected, not yet visible
        drive(1, 0, 0, 0, 0, 1, 0, 1, 1, "R8");
        drive(1, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
        // R7: switch to software source, serial line toggles and is ignored
        for (int i = 0; i < 6; i++) begin
            drive(1, 0, 0, 1, i[0], 1, 0, 0, 0, "R7");
        end
        // R8: the bit holds; carrier follows cycle by cycle (R9)
        for (int i = 0; i < 6; i++) begin
            drive(1, 0, 0, 1, 0, i[0], 1, 0, 0, "R9");
        end
        // R8: write 0, takes effect from the next cycle
        drive(1, 0, 0, 1, 1, 1, 1, 1, 0, "R8");
        drive(1, 0, 0, 1, 1, 1, 1, 0, 0, "R8");
        drive(1, 0, 1, 1, 1, 1, 0, 0, 0, "R7");
        drive(0, 1, 1, 1, 0, 1, 1, 0, 0, "R2");

        @(posedge clk);
        @(posedge clk);
        #5;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule